// File: doc/BRIEF.md
# Windowed DMA Address Translator

This block maps addresses arriving from an I/O bus onto physical DMA addresses. Four programmable windows are checked against each incoming address. Each window has three registers: a base, a size mask and a target base. The base register also carries an enable bit and a mode bit. An enabled window whose compare region matches the address translates it. The first such window, taken from the lowest index upward, is the one used.

A direct-mapped window keeps the low-order offset of the address and replaces the upper bits with the target base. A scatter-gather window works in three steps. It first builds the address of a 64-bit page-table entry from the target base and the bus address. It then reads that entry through a valid/ready read-request channel and waits for the read data. Finally it merges the entry's page number with the 13-bit page offset of the bus address.

Translated results are cut to 34 bits. An address that no enabled window claims leaves the block unchanged. Only one translation is in flight at a time. The result is presented on a valid/ready response port and held there until it is taken.

Top module: `dma_window_xlate`

## Requirements
- R1: A window's compare mask is the inverse of its mask register limited to bits 31:20; the window matches when the bus address and the window base agree in every compare-mask bit, and bus address bits outside 31:20 play no part in matching.
- R2: A window takes part only when bit 0 of its base register is 1; a matching window with bit 0 clear is passed over as if it did not match.
- R3: When several enabled windows match, the one with the lowest index performs the translation.
- R4: With base bit 1 clear the window is direct-mapped: with offset mask M = (mask bits 31:20) | 0xFFFFF, the result is (target & ~M) | (bus address & M).
- R5: With base bit 1 set, the block issues a read of the entry at ((target & ~(((mask bits 31:20) >> 10) | 0x3FF)) | ((bus address & ((mask bits 31:20) | 0xFE000)) >> 10)), and holds the request valid with a stable address until the memory accepts it.
- R6: The scatter-gather result is ((entry & ~1) << 12) | (bus address bits 12:0).
- R7: Every result from a matching window is truncated to 34 bits, so output bits 63:34 are zero.
- R8: When no enabled window matches, the response carries the full 64-bit bus address unchanged.
- R9: A direct-mapped or unmatched request responds the cycle after it is accepted. A scatter-gather request raises no response before its entry returns, and responds the cycle after the read data is taken.
- R10: The request port stays not-ready from acceptance until the response is taken. While the response waits for the consumer, it is held valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | 64 | Bus address to translate |
| win_base_i | input | 256 | Window base registers, window i at bits [64*i +: 64]; bit 0 enable, bit 1 scatter-gather |
| win_mask_i | input | 256 | Window size masks, same packing |
| win_tba_i | input | 256 | Window target bases, same packing |
| mem_req_valid_o | output | 1 | Table entry read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 64 | Table entry address |
| mem_rsp_valid_i | input | 1 | Table entry data valid |
| mem_rsp_data_i | input | 64 | Table entry data |
| rsp_valid_o | output | 1 | Translated address valid |
| rsp_ready_i | input | 1 | Consumer takes the response |
| rsp_addr_o | output | 64 | Translated address |

## Verification
Direct-mapped and unmatched requests are due one cycle after the accepting edge. The bench drives each request before an edge and samples the response at the falling edge that follows. At that point it expects valid high and the exact address. For scatter-gather requests, the entry read address is checked at the first falling edge after acceptance. The bench then withholds the memory handshakes for several cycles and checks that neither a response nor a second acceptance appears. The result is checked at the falling edge after the read data is handed over. Backpressure on the response port is checked by holding ready low over several sampled cycles and comparing the held address each time.

// File: rtl/dwx_pkg.sv
package dwx_pkg;
  localparam int unsigned WIN_LSB     = 20;
  localparam int unsigned WIN_MSB     = 31;
  localparam int unsigned PTE_SHIFT   = 10;
  localparam int unsigned PAGE_SHIFT  = 12;
  localparam int unsigned PG_OFF_BITS = 13;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } xl_state_e;
endpackage

// File: rtl/dwx_win_match.sv
module dwx_win_match
  import dwx_pkg::*;
#(
  parameter int unsigned AW = 64
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] mask_i,
  output logic          hit_o,
  output logic          sg_o
);
  localparam logic [AW-1:0] FIELD = (AW'(1) << (WIN_MSB + 1)) - (AW'(1) << WIN_LSB);

  logic [AW-1:0] cmp_mask;

  assign cmp_mask = ~mask_i & FIELD;
  assign hit_o    = base_i[0] && ((addr_i & cmp_mask) == (base_i & cmp_mask));
  assign sg_o     = base_i[1];
endmodule

// File: rtl/dwx_xlate_calc.sv
module dwx_xlate_calc
  import dwx_pkg::*;
#(
  parameter int unsigned AW = 64
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] mask_i,
  input  logic [AW-1:0] tba_i,
  output logic [AW-1:0] direct_o,
  output logic [AW-1:0] pte_addr_o
);
  localparam logic [AW-1:0] FIELD    = (AW'(1) << (WIN_MSB + 1)) - (AW'(1) << WIN_LSB);
  localparam logic [AW-1:0] LOW_OFF  = (AW'(1) << WIN_LSB) - AW'(1);
  localparam logic [AW-1:0] PTE_LOW  = (AW'(1) << PTE_SHIFT) - AW'(1);
  localparam logic [AW-1:0] PG_INDEX = (AW'(1) << WIN_LSB) - (AW'(1) << PG_OFF_BITS);

  logic [AW-1:0] wm, off_mask, ent_mask, ba_mask;

  assign wm       = mask_i & FIELD;
  assign off_mask = wm | LOW_OFF;
  assign direct_o = (tba_i & ~off_mask) | (addr_i & off_mask);

  assign ent_mask   = ~((wm >> PTE_SHIFT) | PTE_LOW);
  assign ba_mask    = wm | PG_INDEX;
  assign pte_addr_o = (tba_i & ent_mask) | ((addr_i & ba_mask) >> PTE_SHIFT);
endmodule

// File: rtl/dwx_first_hit.sv
module dwx_first_hit #(
  parameter int unsigned N     = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     hit_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] grant;

  always_comb begin
    idx_o = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        idx_o = IDX_W'(i);
        grant = N'(1) << i;
      end
    end
  end

  assign any_o = |hit_i;

  p_grant_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && ((grant != '0) == any_o));

  p_lowest_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i[0] |-> (idx_o == '0));
endmodule

// File: rtl/dma_window_xlate.sv
module dma_window_xlate
  import dwx_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned AW      = 64,
  parameter int unsigned OUT_W   = 34
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [AW-1:0]         req_addr_i,
  input  logic [NUM_WIN*AW-1:0] win_base_i,
  input  logic [NUM_WIN*AW-1:0] win_mask_i,
  input  logic [NUM_WIN*AW-1:0] win_tba_i,
  output logic                  mem_req_valid_o,
  input  logic                  mem_req_ready_i,
  output logic [AW-1:0]         mem_req_addr_o,
  input  logic                  mem_rsp_valid_i,
  input  logic [AW-1:0]         mem_rsp_data_i,
  output logic                  rsp_valid_o,
  input  logic                  rsp_ready_i,
  output logic [AW-1:0]         rsp_addr_o
);
  localparam int unsigned IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam logic [AW-1:0] OUT_MASK = (AW'(1) << OUT_W) - AW'(1);

  logic [NUM_WIN-1:0] hit_vec, sg_vec;
  logic [AW-1:0]      direct_vec [NUM_WIN];
  logic [AW-1:0]      pte_vec    [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    dwx_win_match #(.AW(AW)) u_match (
      .addr_i (req_addr_i),
      .base_i (win_base_i[w*AW +: AW]),
      .mask_i (win_mask_i[w*AW +: AW]),
      .hit_o  (hit_vec[w]),
      .sg_o   (sg_vec[w])
    );
    dwx_xlate_calc #(.AW(AW)) u_calc (
      .addr_i     (req_addr_i),
      .mask_i     (win_mask_i[w*AW +: AW]),
      .tba_i      (win_tba_i[w*AW +: AW]),
      .direct_o   (direct_vec[w]),
      .pte_addr_o (pte_vec[w])
    );
  end

  logic             sel_any;
  logic [IDX_W-1:0] sel_idx;

  dwx_first_hit #(.N(NUM_WIN)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit_vec),
    .any_o  (sel_any),
    .idx_o  (sel_idx)
  );

  xl_state_e              state_q;
  logic [AW-1:0]          pte_q, res_q;
  logic [PG_OFF_BITS-1:0] off_q;
  logic                   xl_q;
  logic                   accept, sel_sg;
  logic [AW-1:0]          sg_res;

  assign req_ready_o     = (state_q == ST_IDLE);
  assign accept          = req_valid_i && req_ready_o;
  assign sel_sg          = sel_any && sg_vec[sel_idx];
  assign sg_res          = ((mem_rsp_data_i & ~AW'(1)) << PAGE_SHIFT) | AW'(off_q);
  assign mem_req_valid_o = (state_q == ST_FETCH);
  assign mem_req_addr_o  = pte_q;
  assign rsp_valid_o     = (state_q == ST_RESP);
  assign rsp_addr_o      = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pte_q   <= '0;
      res_q   <= '0;
      off_q   <= '0;
      xl_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (sel_sg) begin
            pte_q   <= pte_vec[sel_idx];
            off_q   <= req_addr_i[PG_OFF_BITS-1:0];
            state_q <= ST_FETCH;
          end else begin
            res_q   <= sel_any ? (direct_vec[sel_idx] & OUT_MASK) : req_addr_i;
            xl_q    <= sel_any;
            state_q <= ST_RESP;
          end
        end
        ST_FETCH: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          res_q   <= sg_res & OUT_MASK;
          xl_q    <= 1'b1;
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_fast_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !sel_sg) |=> rsp_valid_o);

  p_sg_no_early_rsp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && sel_sg) |=> (mem_req_valid_o && !rsp_valid_o));

  p_mem_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  p_rsp_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_addr_o)));

  p_single_txn_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!rsp_valid_o && !mem_req_valid_o));

  p_trunc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && xl_q) |-> ((rsp_addr_o & ~OUT_MASK) == '0));
endmodule

// File: tb/dma_window_xlate_test.sv
module dma_window_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int AW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [NW*AW-1:0] wbase = '0, wmask = '0, wtba = '0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [AW-1:0] mem_rsp_data = '0;
  logic rsp_valid, rsp_ready = 1'b0;
  logic [AW-1:0] rsp_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_window_xlate uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .win_base_i(wbase), .win_mask_i(wmask), .win_tba_i(wtba),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_addr_o(rsp_addr)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_win(input int i, input logic [AW-1:0] b, input logic [AW-1:0] m,
                         input logic [AW-1:0] t);
    wbase[i*AW +: AW] = b;
    wmask[i*AW +: AW] = m;
    wtba[i*AW +: AW]  = t;
  endtask

  // One translation; inputs change at negedges, outputs sampled at negedges.
  task automatic xlate(input logic [AW-1:0] a, input logic [AW-1:0] d,
                       input logic [AW-1:0] pte, input logic [AW-1:0] exp,
                       input bit sg, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 busy after accept", {63'd0, req_ready}, 64'd0);
    if (!sg) begin
      chk("R9 response one cycle after accept", {63'd0, rsp_valid}, 64'd1);
      chk(tag, rsp_addr, exp);
    end else begin
      chk("R9 no early response", {63'd0, rsp_valid}, 64'd0);
      chk("R5 entry read valid", {63'd0, mem_req_valid}, 64'd1);
      chk("R5 entry address", mem_req_addr, pte);
      repeat (2) @(negedge clk);
      chk("R5 read held until ready", {63'd0, mem_req_valid}, 64'd1);
      chk("R5 read address held", mem_req_addr, pte);
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk("R5 read dropped after accept", {63'd0, mem_req_valid}, 64'd0);
      repeat (3) @(negedge clk);
      chk("R9 stall while entry pending", {63'd0, rsp_valid}, 64'd0);
      chk("R10 no accept while pending", {63'd0, req_ready}, 64'd0);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = d;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk("R9 response one cycle after data", {63'd0, rsp_valid}, 64'd1);
      chk(tag, rsp_addr, exp);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R10 idle after response taken", {62'd0, rsp_valid, req_ready}, 64'd1);
  endtask

  // {sg, addr, entry data, entry address, expected}
  localparam logic [4*AW:0] VEC [9] = '{
    {1'b0, 64'h0000_0000_8001_2345, 64'd0, 64'd0, 64'h0000_0001_2341_2345},
    {1'b0, 64'h0000_0000_40AB_CDEF, 64'd0, 64'd0, 64'h0000_0000_12AB_CDEF},
    {1'b1, 64'h0000_0000_2003_4567, 64'h0000_0000_0012_3457, 64'h0000_0000_0055_00D0, 64'h0000_0001_2345_6567},
    {1'b1, 64'h0000_0000_2003_4567, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0055_00D0, 64'h0000_0003_FFFF_E567},
    {1'b0, 64'h1234_5678_9ABC_DEF0, 64'd0, 64'd0, 64'h1234_5678_9ABC_DEF0},
    {1'b0, 64'h0000_0000_9001_0000, 64'd0, 64'd0, 64'h0000_0000_9001_0000},
    {1'b0, 64'h0000_0000_800F_FFFF, 64'd0, 64'd0, 64'h0000_0001_234F_FFFF},
    {1'b0, 64'h0000_0000_8010_0000, 64'd0, 64'd0, 64'h0000_0000_8010_0000},
    {1'b0, 64'hFF00_0000_8000_0010, 64'd0, 64'd0, 64'h0000_0001_2340_0010}
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R4 direct window 0";
      1: return "R7 direct result truncated";
      2: return "R6 scatter-gather merge";
      3: return "R7 scatter-gather truncated";
      4: return "R8 no match passes through";
      5: return "R2 disabled window skipped";
      6: return "R1 top of window matches";
      7: return "R1 just past window misses";
      default: return "R1 upper bus bits ignored";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    set_win(0, 64'h8000_0001, 64'h0, 64'h1_2340_0000);
    set_win(1, 64'h4000_0001, 64'h00F0_0000, 64'hC_1200_0000);
    set_win(2, 64'h2000_0003, 64'h0, 64'h0055_0000);
    set_win(3, 64'h9000_0000, 64'h0, 64'h5_0000_0000);
    repeat (3) @(negedge clk);
    chk("R10 reset ready", {63'd0, req_ready}, 64'd1);
    chk("R9 reset no response", {63'd0, rsp_valid}, 64'd0);
    chk("R5 reset no read", {63'd0, mem_req_valid}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++)
      xlate(VEC[i][4*AW-1 -: AW], VEC[i][3*AW-1 -: AW], VEC[i][2*AW-1 -: AW],
            VEC[i][AW-1:0], VEC[i][4*AW], vtag(i));

    // R3: overlapping enabled windows, lowest index wins
    set_win(0, 64'h4000_0001, 64'h0, 64'h1_2340_0000);
    xlate(64'h4001_2345, 64'd0, 64'd0, 64'h1_2341_2345, 1'b0, "R3 lowest window wins");
    // R2: lower window disabled, next matching window used
    set_win(0, 64'h4000_0000, 64'h0, 64'h1_2340_0000);
    xlate(64'h4001_2345, 64'd0, 64'd0, 64'h0_1201_2345, 1'b0, "R2 falls to next window");

    // R5/R6 with a 2 MB scatter-gather window
    set_win(0, 64'h8000_0001, 64'h0, 64'h1_2340_0000);
    set_win(2, 64'h2000_0003, 64'h0010_0000, 64'h0055_0000);
    xlate(64'h2013_4567, 64'h000A_BCDE, 64'h0055_04D0, 64'hABCD_E567, 1'b0 | 1'b1,
          "R6 scatter-gather wide window");

    // R10: response held under backpressure
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 64'h8000_0042;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R10 response held valid", {63'd0, rsp_valid}, 64'd1);
      chk("R10 response held value", rsp_addr, 64'h1_2340_0042);
      chk("R10 no accept while held", {63'd0, req_ready}, 64'd0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R10 released", {63'd0, req_ready}, 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule